// File: doc/BRIEF.md
# Dual-Target Priority Interrupt Arbiter

This block gathers interrupt requests from a set of request nodes and steers each one to one of two service targets. Target 0 is the main signal-processing core. Target 1 is the peripheral control processor. Each node stores an 8-bit priority and a one-bit target select. A request pulse on a node's input sets that node's pending flag. Each target has its own arbitration unit. A unit takes a snapshot of the eligible pending nodes on its bus and narrows them to the highest priority. It then raises an interrupt line to its processor and shows the winning priority number beside it.

Each unit resolves the priority two bits per clock, starting from the most significant bits that are in use. Software sets the number of arbitration clocks to 1, 2, 3 or 4. A shorter setting gives lower interrupt latency, but only the smaller priority values can then compete. Each unit also holds a threshold, and it interrupts its processor only when the winner's priority is above that threshold. The processor acknowledges the interrupt. This clears the winning node's pending flag and starts the next round.

Configuration uses a single write port. Addresses below `NODES` select a node. Address `NODES` selects the unit for target 0, and address `NODES+1` selects the unit for target 1.

Top module: `irq_steer_arb`

## Requirements
- R1: A high `src_req[n]` at a rising clock edge sets node n's pending flag. The flag stays set until node n is acknowledged as a winner.
- R2: A node whose priority is 0 never wins and never causes an interrupt.
- R3: A node's target bit (write data bit 8) sends its request to unit 0 when the bit is 0 and to unit 1 when it is 1. The two units arbitrate independently.
- R4: Among the eligible pending nodes on its bus, a unit selects the highest priority. It drives `tgt_irq[u]` high and `tgt_prio` slice u with that priority. Both hold steady until acknowledge or a configuration write.
- R5: When two eligible nodes on one bus share a priority, the node with the lower index wins.
- R6: A unit interrupts only if the winning priority is strictly greater than its threshold (unit write data bits 7:0). A winner at or below the threshold stays pending.
- R7: The unit's cycle field (write data bits 9:8) gives an arbitration length C of field+1 clocks. From an idle unit, the interrupt is visible after the C+2nd rising edge, counted from the edge that captured the request. After an acknowledge, the interrupt stays low for at least two clocks.
- R8: With length C, only priorities below 4^C compete. A higher priority stays pending until a longer setting is chosen.
- R9: An acknowledge while `tgt_irq[u]` is high clears the winner's pending flag at that edge. The interrupt drops on the next clock, and the remaining requests are then arbitrated in order.
- R10: A request captured after a round has taken its snapshot waits for the next round, even if its priority is higher.
- R11: A write with `cfg_addr` below `NODES` configures that node. A write to `NODES+u` configures unit u. No other write changes either.
- R12: After reset both interrupts are low and both priority outputs are 0. All node priorities are 0 and all targets are 0. Both thresholds are 0, and both arbitration lengths are 4 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NODES | Request pulse, one per node |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(NODES)+1 | Configuration address |
| cfg_wdata | input | PRIO_W+2 | Configuration write data |
| tgt_ack | input | 2 | Acknowledge from target 0 and target 1 |
| tgt_irq | output | 2 | Interrupt request to target 0 and target 1 |
| tgt_prio | output | 2*PRIO_W | Winning priority per target, unit 0 in the low byte |

## Verification
A table of request masks over a fixed node setup covers single requests, disabled nodes, requests on one bus only, requests on both buses, and all nodes at once. These patterns separate a wrong maximum from wrong steering or from a disabled node leaking through. Directed runs then cover several further cases:
- acknowledging a burst, which checks that winners come out in descending order;
- a priority tie, observed by reprogramming the loser before the acknowledge, which exposes the index tie-break;
- thresholds at, below and above the winner;
- the three latencies for the different arbitration lengths, together with the out-of-range priority that a short setting must skip;
- a high-priority request that arrives mid-round and must wait.

// File: rtl/irq_steer_arb.sv
module irq_steer_arb #(
  parameter int NODES  = 8,
  parameter int PRIO_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NODES-1:0]                       src_req,
  input  logic                                   cfg_we,
  input  logic [$clog2(NODES):0]                 cfg_addr,
  input  logic [PRIO_W+$clog2(PRIO_W/2)-1:0]     cfg_wdata,
  input  logic [1:0]                             tgt_ack,
  output logic [1:0]                             tgt_irq,
  output logic [2*PRIO_W-1:0]                    tgt_prio
);
  localparam int GROUPS = PRIO_W / 2;
  localparam int SW     = $clog2(GROUPS);
  localparam int AW     = $clog2(NODES) + 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_ARB = 2'd1, S_RES = 2'd2;

  logic [PRIO_W-1:0]       prio_q [NODES];
  logic [NODES-1:0]        dest_q, pend_q;
  logic [1:0][NODES-1:0]   clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) prio_q[n] <= '0;
      dest_q <= '0;
    end else if (cfg_we) begin
      for (int n = 0; n < NODES; n++)
        if (cfg_addr == AW'(n)) begin
          prio_q[n] <= cfg_wdata[PRIO_W-1:0];
          dest_q[n] <= cfg_wdata[PRIO_W];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~(clr_v[0] | clr_v[1])) | src_req;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic [1:0]        st_q;
    logic [SW-1:0]     lvl_q, cyc_q;
    logic [PRIO_W-1:0] thr_q, win_p;
    logic [NODES-1:0]  cand_q, elig, keep, win_oh;
    logic [1:0]        gmax;
    logic              fire;

    always_comb begin
      gmax  = '0;
      win_p = '0;
      for (int n = 0; n < NODES; n++) begin
        elig[n] = pend_q[n] && (dest_q[n] == 1'(u)) && (prio_q[n] != '0) &&
                  ((prio_q[n] >> (2*int'(cyc_q) + 2)) == '0);
        if (cand_q[n] && prio_q[n][2*lvl_q +: 2] > gmax) gmax = prio_q[n][2*lvl_q +: 2];
      end
      for (int n = 0; n < NODES; n++) begin
        keep[n] = cand_q[n] && (prio_q[n][2*lvl_q +: 2] == gmax);
        if (win_oh[n]) win_p |= prio_q[n];
      end
    end

    assign win_oh = cand_q & (~cand_q + 1'b1);
    assign fire   = (st_q == S_RES) && (win_p > thr_q);
    assign clr_v[u] = (fire && tgt_ack[u]) ? win_oh : '0;
    assign tgt_irq[u] = fire;
    assign tgt_prio[u*PRIO_W +: PRIO_W] = fire ? win_p : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= S_IDLE;
        lvl_q  <= '0;
        cand_q <= '0;
        thr_q  <= '0;
        cyc_q  <= '1;
      end else begin
        if (cfg_we && cfg_addr == AW'(NODES + u)) begin
          thr_q <= cfg_wdata[PRIO_W-1:0];
          cyc_q <= cfg_wdata[PRIO_W +: SW];
        end
        case (st_q)
          S_IDLE: if (|elig) begin
            cand_q <= elig;
            lvl_q  <= cyc_q;
            st_q   <= S_ARB;
          end
          S_ARB: begin
            cand_q <= keep;
            if (lvl_q == '0) st_q <= S_RES;
            else             lvl_q <= lvl_q - 1'b1;
          end
          S_RES: if (!fire || tgt_ack[u]) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end

    a_r9_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq[u] && tgt_ack[u] |=> !tgt_irq[u]);
    a_r7_quiet_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq[u] && tgt_ack[u] |-> ##2 !tgt_irq[u]);
    a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq[u] && !tgt_ack[u] && !cfg_we |=> tgt_irq[u] && $stable(tgt_prio[u*PRIO_W +: PRIO_W]));
    a_r2_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq[u] |-> tgt_prio[u*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: tb/test_irq_steer_arb.sv
`timescale 1ns/1ps
module test_irq_steer_arb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  src_req = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [9:0]  cfg_wdata = '0;
  logic [1:0]  tgt_ack = '0, tgt_irq;
  logic [15:0] tgt_prio;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_steer_arb i_irq_steer_arb (.clk, .rst_n, .src_req, .cfg_we, .cfg_addr,
    .cfg_wdata, .tgt_ack, .tgt_irq, .tgt_prio);

  // mask, expected unit0 priority, expected unit1 priority (0 = no interrupt)
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'd10,  8'd0},   {8'h03, 8'd200, 8'd0},
    {8'h04, 8'd0,   8'd0},   {8'h08, 8'd0,   8'd37},
    {8'hB8, 8'd0,   8'd200}, {8'hFF, 8'd200, 8'd200},
    {8'h49, 8'd10,  8'd37},  {8'h90, 8'd0,   8'd120}};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg_node(input int n, input int p, input bit d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(n); cfg_wdata = {1'b0, d, 8'(p)};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_unit(input int u, input int thr, input int cyc);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(8 + u); cfg_wdata = {2'(cyc), 8'(thr)};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  task automatic wait_irq(input int u, input int maxc, output int k);
    k = 1;
    while (!tgt_irq[u] && k < maxc) begin @(negedge clk); k++; end
  endtask

  function automatic int pr(input int u);
    return tgt_irq[u] ? int'(tgt_prio[u*8 +: 8]) : 0;
  endfunction

  task automatic ack(input int u, input string rq);
    tgt_ack[u] = 1'b1;
    @(negedge clk); tgt_ack[u] = 1'b0;
    chk(!tgt_irq[u], rq, tgt_irq[u], 0);
  endtask

  task automatic drain();
    repeat (60) begin @(negedge clk); tgt_ack = tgt_irq; end
    @(negedge clk); tgt_ack = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_prio(input int u, input int exp, input string rq);
    int k;
    wait_irq(u, 20, k);
    chk(pr(u) == exp, rq, pr(u), exp);
  endtask

  task automatic expect_none(input int u, input string rq);
    repeat (15) @(negedge clk);
    chk(!tgt_irq[u], rq, tgt_irq[u], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(tgt_irq == 2'b00 && tgt_prio == '0, "R12 reset outputs", tgt_prio, 0);
    rst_n = 1'b1;
    // R12: reset length is 4 clocks, so a priority of 200 is in range
    cfg_node(1, 200, 0);
    pulse(8'h02); wait_irq(0, 20, k);
    chk(k == 6, "R12 R7 default length latency", k, 6);
    chk(pr(0) == 200, "R12 default threshold", pr(0), 200);
    ack(0, "R9 drop after ack");

    cfg_node(0, 10, 0);  cfg_node(2, 0, 0);   cfg_node(3, 37, 1);
    cfg_node(4, 120, 1); cfg_node(5, 200, 1); cfg_node(6, 5, 0);
    cfg_node(7, 64, 1);

    // R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i][23:16]);
      repeat (10) @(negedge clk);
      chk(pr(0) == int'(VEC[i][15:8]), $sformatf("R4 R2 R3 vec %0d unit0", i), pr(0), VEC[i][15:8]);
      chk(pr(1) == int'(VEC[i][7:0]),  $sformatf("R4 R2 R3 vec %0d unit1", i), pr(1), VEC[i][7:0]);
      drain();
    end

    // R9: burst comes out in descending order
    pulse(8'h43);
    expect_prio(0, 200, "R9 first of burst");  ack(0, "R9 drop");
    expect_prio(0, 10,  "R9 second of burst"); ack(0, "R9 drop");
    expect_prio(0, 5,   "R9 third of burst");  ack(0, "R9 drop");
    expect_none(0, "R9 burst empty");

    // R5: tie, lowest index wins; the loser is reprogrammed before the ack
    cfg_node(6, 10, 0);
    pulse(8'h41);
    expect_prio(0, 10, "R5 tie winner");
    cfg_node(6, 7, 0);
    chk(pr(0) == 10, "R5 winner is node 0", pr(0), 10);
    ack(0, "R9 drop");
    expect_prio(0, 7, "R5 node 6 left pending");
    ack(0, "R9 drop");
    cfg_node(6, 5, 0);

    // R6 R1: threshold
    cfg_unit(0, 10, 3);
    pulse(8'h01);
    expect_none(0, "R6 equal to threshold");
    pulse(8'h02);
    expect_prio(0, 200, "R6 above threshold");
    ack(0, "R9 drop");
    expect_none(0, "R6 still blocked");
    cfg_unit(0, 9, 3);
    expect_prio(0, 10, "R1 pending kept across rounds");
    ack(0, "R9 drop");
    cfg_unit(0, 0, 3);

    // R7: latency for each length
    pulse(8'h40); wait_irq(0, 20, k);
    chk(k == 6, "R7 length 4 latency", k, 6);
    ack(0, "R9 drop");
    cfg_node(6, 3, 0);
    cfg_unit(0, 0, 0);
    pulse(8'h40); wait_irq(0, 20, k);
    chk(k == 3, "R7 length 1 latency", k, 3);
    ack(0, "R9 drop");
    cfg_unit(0, 0, 1);
    pulse(8'h40); wait_irq(0, 20, k);
    chk(k == 4, "R7 length 2 latency", k, 4);
    ack(0, "R9 drop");

    // R8: short length skips out-of-range priority
    cfg_unit(0, 0, 0);
    pulse(8'h41);
    expect_prio(0, 3, "R8 in-range wins");
    ack(0, "R9 drop");
    expect_none(0, "R8 out-of-range waits");
    cfg_unit(0, 0, 3);
    expect_prio(0, 10, "R8 served after longer length");
    ack(0, "R9 drop");
    cfg_node(6, 5, 0);

    // R10: arrival after snapshot waits
    @(negedge clk); src_req = 8'h40;
    @(negedge clk); src_req = 8'h02;
    @(negedge clk); src_req = 8'h00;
    expect_prio(0, 5, "R10 late request excluded");
    ack(0, "R9 drop");
    expect_prio(0, 200, "R10 late request next round");
    ack(0, "R9 drop");

    // R3: steering change
    cfg_node(0, 10, 1);
    pulse(8'h01);
    expect_prio(1, 10, "R3 steered to unit1");
    chk(!tgt_irq[0], "R3 unit0 untouched", tgt_irq[0], 0);
    ack(1, "R9 drop");
    cfg_node(0, 10, 0);

    // R11: unit1 address
    cfg_unit(1, 200, 3);
    pulse(8'h20);
    expect_none(1, "R11 unit1 threshold written");
    cfg_unit(1, 0, 3);
    expect_prio(1, 200, "R11 unit1 threshold cleared");
    ack(1, "R9 drop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule